// File: doc/BRIEF.md
# Lockable Shadowed Pulse-Width Modulator

This block is a single-channel pulse-width modulator driven through a plain register strobe. Software writes a period and a duty value, both counted in input clock ticks, and a control word. The control word starts the channel and picks the output levels for the duty phase and the idle phase. The waveform is left-aligned: each period begins with its duty phase.

Period, duty and the two level bits are never applied mid-period. The written values sit in a staging set, and an active set drives the waveform. The active set is reloaded from the staging set only at a period boundary, or on every cycle while the channel is stopped. A lock bit in the control word holds back this reload. Software can therefore stage several changes under lock, clear the lock, and have all of them start together at the following boundary.

Top module: `lkpwm_top`

## Requirements
- R1: After a synchronous active-high reset, all registers read 0, the count is 0 and `pwm_out` is 0.
- R2: Address bits [3:2] pick the register: 0 count, 1 period, 2 duty, 3 control. Other address bits are ignored. `rdata` returns the selected register one cycle after the address is presented. Control keeps only bits 0, 1, 3, 4, 5, 6 and 8; all other control bits read back as 0.
- R3: The count register reads back the live count. A write to it changes no register.
- R4: The channel runs only when control bit 0 (enable) and bit 1 (continuous) are both 1. Otherwise the count is held at 0 and the output is the active idle level.
- R5: While running, the count rises by one per clock. It returns to 0 on the cycle where count+1 ≥ active period, so each period lasts exactly `period` ticks.
- R6: While running, `pwm_out` takes the duty level (control bit 3) when count < active duty, and the idle level (control bit 4) otherwise. The output is registered one cycle behind the count.
- R7: A duty of 0 gives a constant idle level. A duty ≥ period gives a constant duty level. A period of 0 holds the output at the idle level.
- R8: With control bit 6 (lock) clear, staged period, duty and level bits become active only at a period boundary, or on the next clock while stopped.
- R9: While the lock bit is 1, the active period, duty and levels do not change.
- R10: After the lock is cleared, all staged values become active together at the first boundary reached with the lock clear.
- R11: Control bits 5 (alignment) and 8 (low power) are stored and read back, but have no effect on the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the counting tick |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 4 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pwm_out | output | 1 | Modulated output |

## Verification
A write lands in the staging register at the edge where `wr_en` is sampled. Read data for an address is valid after the next edge. Run and lock changes act from the cycle after their write. A staged value reaches the active set at the first boundary edge, and `pwm_out` reflects a count and active set one edge later. The bench keeps a cycle model updated on the rising edge. It compares `rdata` and `pwm_out` against that model on every falling edge, so each check is made half a cycle after the edge that produced the value. Directed level counts are taken over whole periods only once the new values have had a full period to commit.

// File: rtl/lkpwm_pkg.sv
package lkpwm_pkg;
  localparam int CB_EN    = 0;
  localparam int CB_CONT  = 1;
  localparam int CB_DLVL  = 3;
  localparam int CB_ILVL  = 4;
  localparam int CB_ALIGN = 5;
  localparam int CB_LOCK  = 6;
  localparam int CB_LP    = 8;

  typedef enum logic [1:0] {
    SEL_CNT  = 2'd0,
    SEL_PER  = 2'd1,
    SEL_DUTY = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic dlvl;
    logic ilvl;
  } pol_t;
endpackage

// File: rtl/lkpwm_regfile.sv
module lkpwm_regfile
  import lkpwm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cnt,
  output logic [DATA_W-1:0] per_w,
  output logic [DATA_W-1:0] duty_w,
  output logic [DATA_W-1:0] ctrl_w,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [DATA_W-1:0] CTRL_MASK =
    (DATA_W'(1) << CB_EN)   | (DATA_W'(1) << CB_CONT) |
    (DATA_W'(1) << CB_DLVL) | (DATA_W'(1) << CB_ILVL) |
    (DATA_W'(1) << CB_ALIGN)| (DATA_W'(1) << CB_LOCK) |
    (DATA_W'(1) << CB_LP);

  reg_sel_e sel;
  assign sel = reg_sel_e'(addr[3:2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      per_w  <= '0;
      duty_w <= '0;
      ctrl_w <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_PER:  per_w  <= wdata;
        SEL_DUTY: duty_w <= wdata;
        SEL_CTRL: ctrl_w <= wdata & CTRL_MASK;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (sel)
        SEL_CNT:  rdata <= cnt;
        SEL_PER:  rdata <= per_w;
        SEL_DUTY: rdata <= duty_w;
        default:  rdata <= ctrl_w;
      endcase
    end
  end

  // R3: a count-address write leaves every stored register untouched
  assert_cnt_write_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_CNT) |=> ($stable(per_w) && $stable(duty_w) && $stable(ctrl_w)));

  // R2: control never holds an unimplemented bit
  assert_ctrl_mask_R2: assert property (@(posedge clk) disable iff (rst)
    (ctrl_w & ~CTRL_MASK) == '0);
endmodule

// File: rtl/lkpwm_shadow.sv
module lkpwm_shadow
  import lkpwm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] per_w,
  input  logic [DATA_W-1:0] duty_w,
  input  pol_t              pol_w,
  input  logic              lock,
  input  logic              commit,
  output logic [DATA_W-1:0] per_a,
  output logic [DATA_W-1:0] duty_a,
  output pol_t              pol_a
);
  logic load;
  assign load = commit && !lock;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_a  <= '0;
      duty_a <= '0;
      pol_a  <= '0;
    end else if (load) begin
      per_a  <= per_w;
      duty_a <= duty_w;
      pol_a  <= pol_w;
    end
  end

  // R9: locked means the active set holds
  assert_lock_hold_R9: assert property (@(posedge clk) disable iff (rst)
    lock |=> ($stable(per_a) && $stable(duty_a) && $stable(pol_a)));

  // R8: the active set changes only after a boundary from the counter
  assert_commit_at_boundary_R8: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(per_a) && $stable(duty_a) && $stable(pol_a)));
endmodule

// File: rtl/lkpwm_counter.sv
module lkpwm_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [DATA_W-1:0] per_a,
  output logic [DATA_W-1:0] cnt,
  output logic              commit
);
  logic [DATA_W:0] cnt_inc;
  logic            wrap;

  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign wrap    = cnt_inc >= {1'b0, per_a};
  assign commit  = !run || wrap;

  always_ff @(posedge clk) begin
    if (rst || commit) cnt <= '0;
    else               cnt <= cnt_inc[DATA_W-1:0];
  end

  // R5: a running count stays inside the active period
  assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    (run && per_a != '0) |-> (cnt < per_a));

  // R4: stopped channel holds the count at zero
  assert_stopped_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));
endmodule

// File: rtl/lkpwm_outgen.sv
module lkpwm_outgen
  import lkpwm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [DATA_W-1:0] cnt,
  input  logic [DATA_W-1:0] per_a,
  input  logic [DATA_W-1:0] duty_a,
  input  pol_t              pol_a,
  output logic              pwm_out
);
  logic in_duty;
  assign in_duty = run && (per_a != '0) && (cnt < duty_a);

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= 1'b0;
    else     pwm_out <= in_duty ? pol_a.dlvl : pol_a.ilvl;
  end

  // R4: stopped output sits at the idle level
  assert_stopped_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pwm_out == $past(pol_a.ilvl)));

  // R7: zero duty never shows the duty level
  assert_zero_duty_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (duty_a == '0) |=> (pwm_out == $past(pol_a.ilvl)));
endmodule

// File: rtl/lkpwm_top.sv
module lkpwm_top
  import lkpwm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              pwm_out
);
  logic [DATA_W-1:0] per_w, duty_w, ctrl_w;
  logic [DATA_W-1:0] per_a, duty_a, cnt;
  pol_t              pol_w, pol_a;
  logic              run, lock, commit;

  assign run   = ctrl_w[CB_EN] && ctrl_w[CB_CONT];
  assign lock  = ctrl_w[CB_LOCK];
  assign pol_w = '{dlvl: ctrl_w[CB_DLVL], ilvl: ctrl_w[CB_ILVL]};

  lkpwm_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cnt(cnt), .per_w(per_w), .duty_w(duty_w), .ctrl_w(ctrl_w), .rdata(rdata)
  );

  lkpwm_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .per_a(per_a), .cnt(cnt), .commit(commit)
  );

  lkpwm_shadow #(.DATA_W(DATA_W)) u_shadow (
    .clk(clk), .rst(rst), .per_w(per_w), .duty_w(duty_w), .pol_w(pol_w),
    .lock(lock), .commit(commit), .per_a(per_a), .duty_a(duty_a), .pol_a(pol_a)
  );

  lkpwm_outgen #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .run(run), .cnt(cnt), .per_a(per_a),
    .duty_a(duty_a), .pol_a(pol_a), .pwm_out(pwm_out)
  );

  // R10: a staged period becomes active only with the lock clear
  assert_unlock_commit_R10: assert property (@(posedge clk) disable iff (rst)
    (per_a != $past(per_a)) |-> !$past(lock));
endmodule

// File: tb/sim_lkpwm_top.sv
`timescale 1ns/1ps
module sim_lkpwm_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        pwm_out;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";
  bit   done = 1'b0;

  always #10 clk = ~clk;

  lkpwm_top u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
                .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out));

  // reference model state, from the requirements
  logic [31:0] m_per, m_duty, m_ctrl, m_pa, m_da, m_cnt, m_rd;
  logic        m_dl, m_il, m_out;

  function automatic logic [31:0] mask_ctrl(input logic [31:0] v);
    return v & 32'h0000_017B;
  endfunction

  always @(posedge clk) begin
    logic run, lk, bnd, nout;
    logic [31:0] nrd;
    if (rst) begin
      m_per = 0; m_duty = 0; m_ctrl = 0; m_pa = 0; m_da = 0; m_cnt = 0;
      m_rd = 0; m_dl = 0; m_il = 0; m_out = 0;
    end else begin
      run  = m_ctrl[0] & m_ctrl[1];
      lk   = m_ctrl[6];
      nout = (run && m_pa != 0 && m_cnt < m_da) ? m_dl : m_il;
      case (addr[3:2])
        2'd0: nrd = m_cnt;
        2'd1: nrd = m_per;
        2'd2: nrd = m_duty;
        default: nrd = m_ctrl;
      endcase
      bnd = !run || ({32'd0, m_cnt} + 64'd1 >= {32'd0, m_pa});
      if (bnd && !lk) begin
        m_pa = m_per; m_da = m_duty; m_dl = m_ctrl[3]; m_il = m_ctrl[4];
      end
      m_cnt = bnd ? 32'd0 : m_cnt + 1;
      m_out = nout;
      m_rd  = nrd;
      if (wr_en) begin
        case (addr[3:2])
          2'd1: m_per  = wdata;
          2'd2: m_duty = wdata;
          2'd3: m_ctrl = mask_ctrl(wdata);
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", t, act, exp, $time);
    end
  endtask

  // continuous comparison half a cycle after each edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check({tag, " pwm_out"}, {31'd0, pwm_out}, {31'd0, m_out});
      check({tag, " rdata"}, rdata, m_rd);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic count_high(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) c++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int c;
    void'($urandom(32'd4242));
    rst = 1'b1; wr_en = 1'b0; addr = 4'h0; wdata = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset values
    tag = "R1";
    check("R1 pwm_out reset", {31'd0, pwm_out}, 32'd0);
    for (int a = 0; a < 4; a++) begin
      rd(4'(a * 4), v);
      check("R1 reg reset", v, 32'd0);
    end

    // R2: register map and control mask
    tag = "R2";
    wr(4'h4, 32'h1234_5678);
    wr(4'h8, 32'h0BAD_F00D);
    wr(4'hC, 32'hFFFF_FFBC);
    rd(4'h4, v); check("R2 period readback", v, 32'h1234_5678);
    rd(4'h9, v); check("R2 duty readback low bits ignored", v, 32'h0BAD_F00D);
    rd(4'hC, v); check("R2 control masked", v, 32'h0000_0138);
    wr(4'hC, 32'h0);

    // R3: live count, writes ignored
    tag = "R3";
    wr(4'h4, 32'd50);
    wr(4'h8, 32'd10);
    wr(4'hC, 32'h0B);
    idle(4);
    wr(4'h0, 32'hDEAD_BEEF);
    rd(4'h4, v); check("R3 period unchanged by count write", v, 32'd50);
    rd(4'h0, v);
    @(negedge clk); v2 = rdata;
    check("R3 count advances", v2, (v + 1) % 50);

    // R5/R6: period 8 duty 3, normal levels
    tag = "R6";
    wr(4'h4, 32'd8);
    wr(4'h8, 32'd3);
    idle(60);
    count_high(8, c); check("R6 duty ticks high", c, 3);
    count_high(16, c); check("R5 two periods", c, 6);

    // R7: duty corner cases
    tag = "R7";
    wr(4'h8, 32'd0); idle(20);
    count_high(8, c); check("R7 duty zero", c, 0);
    wr(4'h8, 32'd9); idle(20);
    count_high(8, c); check("R7 duty above period", c, 8);
    wr(4'h4, 32'd0); idle(20);
    count_high(8, c); check("R7 period zero", c, 0);
    wr(4'h4, 32'd8); wr(4'h8, 32'd3);

    // R6: inverted levels, low for duty
    tag = "R6";
    wr(4'hC, 32'h13); idle(20);
    count_high(8, c); check("R6 inverted", c, 5);

    // R4: stop -> idle level (high under inverted levels)
    tag = "R4";
    wr(4'hC, 32'h11); idle(4);
    count_high(8, c); check("R4 stopped idle high", c, 8);
    wr(4'hC, 32'h09); idle(4);
    count_high(8, c); check("R4 enable without continuous", c, 0);
    rd(4'h0, v); check("R4 count held zero", v, 32'd0);

    // R9/R10: lock holds staged values, unlock applies them together
    tag = "R9";
    wr(4'hC, 32'h0B); idle(20);
    wr(4'hC, 32'h4B);
    wr(4'h4, 32'd20);
    wr(4'h8, 32'd12);
    wr(4'hC, 32'h53);
    idle(40);
    count_high(8, c); check("R9 locked waveform unchanged", c, 3);
    tag = "R10";
    wr(4'hC, 32'h13); idle(40);
    count_high(20, c); check("R10 new period and levels", c, 8);

    // R8: unlocked change defers to boundary (model compares each cycle)
    tag = "R8";
    wr(4'hC, 32'h0B);
    wr(4'h4, 32'd30); wr(4'h8, 32'd7);
    idle(70);
    count_high(30, c); check("R8 after boundary", c, 7);

    // R11: alignment and low-power bits inert
    tag = "R11";
    wr(4'hC, 32'h12B); idle(40);
    count_high(30, c); check("R11 inert bits", c, 7);
    rd(4'hC, v); check("R11 readback", v, 32'h12B);

    // random mix, checked every cycle against the model
    tag = "R8";
    for (int i = 0; i < 600; i++) begin
      int k;
      k = $urandom_range(0, 9);
      if (k < 3)      wr(4'h4, $urandom_range(0, 20));
      else if (k < 6) wr(4'h8, $urandom_range(0, 24));
      else if (k < 8) wr(4'hC, ($urandom & 32'h17B) | 32'h3);
      else if (k < 9) wr(4'hC, $urandom);
      else            wr(4'h0, $urandom);
      addr = 4'($urandom_range(0, 15));
      idle($urandom_range(0, 12));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule